// File: doc/BRIEF.md
# DMA Channel Start Gate

This block decides, cycle by cycle, whether one DMA channel may move data. It holds the channel's enable bit and three sticky status flags: transfer end, non-maskable interrupt, and address error. It combines them with a global master enable and the selected request source to produce a transfer-permitted strobe and a registered active-transfer state. The request source is one of four modes: always requested, an external line sampled by level, the same line sampled by edge, or a peripheral request.

Software reaches the enable bit and the flags through one small register port. A flag cannot be wiped by a blind write of zeros. The write must follow a read that saw the flag set. A read that coincides with the hardware setting the flag returns 0 but still counts as having seen it set. The external request is resynchronized before use. In edge mode a detected edge is held as a pending request until a transfer starts or the channel is disabled.

Top module: `dma_start_gate`

## Requirements
- R1: After reset the enable bit and all three flags read 0 (reg_rdata = 4'b0000), and xfer_ok and xfer_active are 0.
- R2: In mode 0 (auto), xfer_ok is 1 in the cycle after the enable bit is written to 1, provided master_en is 1 and no flag is set. Any set flag, or master_en at 0, holds xfer_ok at 0.
- R3: In modes 1, 2 and 3, setting the enable bit alone does not raise xfer_ok. A request must also be present.
- R4: In mode 1 (external level) and mode 3 (peripheral), the NMI and address-error flags block a transfer. The transfer-end flag blocks only while te_mask is 0.
- R5: In mode 2 (external edge), any of the three flags blocks a transfer, whatever te_mask is.
- R6: The enable bit is reg_rdata[0] and is loaded from reg_wdata[0] on every write. Writing 0 there drops xfer_ok from the next cycle on.
- R7: The flags read at reg_rdata[1] (transfer end), reg_rdata[2] (NMI) and reg_rdata[3] (address error). A flag clears only when a write carries 0 in its bit and an earlier read saw it at 1 with no write in between. Writing 1 never sets or changes a flag.
- R8: A read in the same cycle that a flag's set event arrives returns 0 for that flag, yet a following write of 0 clears it.
- R9: When a set event and a clearing write meet in one cycle, the flag ends up at 1.
- R10: The external request passes two synchronizer stages. In level mode, a request driven to the req_pol level raises xfer_ok two cycles later. In edge mode, the edge selected by req_pol (1 = rising, 0 = falling) raises xfer_ok three cycles later. The pending edge survives a blocking flag but is lost when the channel is disabled.
- R11: term_count forces xfer_ok to 0 in its own cycle and sets the transfer-end flag, and xfer_active is 0 in the next cycle. A restart then follows the mode's flag rules.
- R12: xfer_active equals xfer_ok of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: bit 0 enable, bits 1..3 flag clears |
| reg_rdata | output | 4 | Read data: bit 0 enable, bits 1..3 flags |
| master_en | input | 1 | Global master enable |
| te_mask | input | 1 | Ignore transfer-end flag in level and peripheral modes |
| req_mode | input | 2 | 0 auto, 1 external level, 2 external edge, 3 peripheral |
| req_pol | input | 1 | External request polarity: 1 high/rising, 0 low/falling |
| ext_req_async | input | 1 | Unsynchronized external request line |
| periph_req | input | 1 | Peripheral request |
| term_count | input | 1 | Terminal-count event from the byte counter |
| nmi_event | input | 1 | NMI set event |
| addr_err_event | input | 1 | Address-error set event |
| xfer_ok | output | 1 | Transfer permitted this cycle |
| xfer_active | output | 1 | Registered active-transfer state |

## Verification
The bench sweeps every mode, mask setting and flag combination. A gate that applied the wrong flag set, or that honoured the mask in edge or auto mode, would permit or refuse transfers in the wrong cells. It aims at the read-clear handshake: a blind zero write, a write of 1, a read racing the set, and a clear racing a set. A design lacking the armed state, or giving the clear priority, would lose or keep a flag wrongly. It counts the synchronizer and edge latency exactly. It also checks that a pending edge survives a blocking flag but not a disable, so an off-by-one pipeline or a pending bit that ignores the enable shows up as a wrong xfer_ok cycle.

// File: rtl/dmagate_pkg.sv
`timescale 1ns/1ps
package dmagate_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO      = 2'd0,
        MODE_EXT_LEVEL = 2'd1,
        MODE_EXT_EDGE  = 2'd2,
        MODE_PERIPH    = 2'd3
    } req_mode_e;

    localparam int NFLAG        = 3;
    localparam int FLG_TE       = 0;
    localparam int FLG_NMI      = 1;
    localparam int FLG_AE       = 2;
    localparam int REG_EN_BIT   = 0;
    localparam int REG_FLAG_LSB = 1;
    localparam int REG_W        = REG_FLAG_LSB + NFLAG;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    // Which flags stop a transfer in the given mode.
    function automatic flag_vec_t blocking_flags(req_mode_e m, logic mask_te);
        flag_vec_t v;
        v = '1;
        if ((m == MODE_EXT_LEVEL || m == MODE_PERIPH) && mask_te)
            v[FLG_TE] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/dmagate_flag_cell.sv
`timescale 1ns/1ps
module dmagate_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic clr_req;

    assign clr_req = wr_i & ~wbit_i & armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            // a set event beats a clearing write
            flag_q <= set_i | (flag_q & ~clr_req);
            if (wr_i)
                armed_q <= 1'b0;
            else if (rd_i && (flag_q || set_i))
                armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dmagate_req_front.sv
`timescale 1ns/1ps
module dmagate_req_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    input  logic pol_i,
    input  logic chan_en_i,
    input  logic consume_i,
    output logic level_o,
    output logic pend_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   synced;
    logic                   edge_hit;

    assign synced   = chain_q[SYNC_STAGES-1];
    assign edge_hit = pol_i ? (synced & ~prev_q) : (~synced & prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
            prev_q  <= synced;
            pend_q  <= chan_en_i & (edge_hit | (pend_q & ~consume_i));
        end
    end

    assign level_o = (synced == pol_i);
    assign pend_o  = pend_q;
endmodule

// File: rtl/dmagate_eval.sv
`timescale 1ns/1ps
module dmagate_eval
    import dmagate_pkg::*;
(
    input  req_mode_e mode_i,
    input  logic      te_mask_i,
    input  flag_vec_t flags_i,
    input  logic      chan_en_i,
    input  logic      master_en_i,
    input  logic      active_i,
    input  logic      level_req_i,
    input  logic      pend_req_i,
    input  logic      periph_req_i,
    input  logic      term_i,
    output logic      permit_o,
    output logic      consume_o
);
    logic blocked;
    logic req_now;

    always_comb begin
        blocked = |(flags_i & blocking_flags(mode_i, te_mask_i));
        unique case (mode_i)
            MODE_AUTO:      req_now = 1'b1;
            MODE_EXT_LEVEL: req_now = level_req_i;
            MODE_EXT_EDGE:  req_now = pend_req_i;
            MODE_PERIPH:    req_now = periph_req_i;
            default:        req_now = 1'b0;
        endcase
        permit_o  = chan_en_i & master_en_i & ~blocked & ~term_i
                  & (active_i | req_now);
        consume_o = permit_o & ~active_i & (mode_i == MODE_EXT_EDGE);
    end
endmodule

// File: rtl/dma_start_gate.sv
`timescale 1ns/1ps
module dma_start_gate
    import dmagate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             master_en,
    input  logic             te_mask,
    input  logic [1:0]       req_mode,
    input  logic             req_pol,
    input  logic             ext_req_async,
    input  logic             periph_req,
    input  logic             term_count,
    input  logic             nmi_event,
    input  logic             addr_err_event,
    output logic             xfer_ok,
    output logic             xfer_active
);
    reg_req_t  bus;
    req_mode_e mode;
    flag_vec_t flags;
    flag_vec_t set_ev;
    logic      en_q;
    logic      active_q;
    logic      level_req;
    logic      pend_req;
    logic      permit;
    logic      consume;

    assign bus.rd    = reg_rd;
    assign bus.wr    = reg_wr;
    assign bus.wdata = reg_wdata;
    assign mode      = req_mode_e'(req_mode);

    always_comb begin
        set_ev          = '0;
        set_ev[FLG_TE]  = term_count;
        set_ev[FLG_NMI] = nmi_event;
        set_ev[FLG_AE]  = addr_err_event;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        dmagate_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_ev[i]),
            .rd_i   (bus.rd),
            .wr_i   (bus.wr),
            .wbit_i (bus.wdata[REG_FLAG_LSB+i]),
            .flag_o (flags[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (bus.wr)
                en_q <= bus.wdata[REG_EN_BIT];
            active_q <= permit;
        end
    end

    dmagate_req_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .async_i   (ext_req_async),
        .pol_i     (req_pol),
        .chan_en_i (en_q),
        .consume_i (consume),
        .level_o   (level_req),
        .pend_o    (pend_req)
    );

    dmagate_eval u_eval (
        .mode_i       (mode),
        .te_mask_i    (te_mask),
        .flags_i      (flags),
        .chan_en_i    (en_q),
        .master_en_i  (master_en),
        .active_i     (active_q),
        .level_req_i  (level_req),
        .pend_req_i   (pend_req),
        .periph_req_i (periph_req),
        .term_i       (term_count),
        .permit_o     (permit),
        .consume_o    (consume)
    );

    always_comb begin
        reg_rdata                                   = '0;
        reg_rdata[REG_EN_BIT]                       = en_q;
        reg_rdata[REG_FLAG_LSB +: NFLAG]            = flags;
    end

    assign xfer_ok     = permit;
    assign xfer_active = active_q;
endmodule

// File: rtl/dma_start_gate_chk.sv
`timescale 1ns/1ps
module dma_start_gate_chk
    import dmagate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [1:0]       req_mode,
    input logic             periph_req,
    input logic             term_count,
    input logic             xfer_ok,
    input logic             xfer_active,
    input flag_vec_t        flags
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!xfer_active && reg_rdata == '0));

    p_auto_flag_block_r2: assert property (@(posedge clk) disable iff (rst)
        (req_mode == MODE_AUTO && |flags) |-> !xfer_ok);

    p_periph_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        (req_mode == MODE_PERIPH && !periph_req && !xfer_active) |-> !xfer_ok);

    p_nmi_ae_block_r4: assert property (@(posedge clk) disable iff (rst)
        (flags[FLG_NMI] || flags[FLG_AE]) |-> !xfer_ok);

    p_edge_te_block_r5: assert property (@(posedge clk) disable iff (rst)
        (req_mode == MODE_EXT_EDGE && flags[FLG_TE]) |-> !xfer_ok);

    p_disable_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[REG_EN_BIT]) |=> !xfer_ok);

    p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[REG_FLAG_LSB+FLG_TE] && flags[FLG_TE]) |=> flags[FLG_TE]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        term_count |=> flags[FLG_TE]);

    p_tc_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        term_count |-> !xfer_ok);

    p_tc_drops_active_r11: assert property (@(posedge clk) disable iff (rst)
        term_count |=> !xfer_active);

    p_active_rise_r12: assert property (@(posedge clk) disable iff (rst)
        xfer_ok |=> xfer_active);

    p_active_fall_r12: assert property (@(posedge clk) disable iff (rst)
        !xfer_ok |=> !xfer_active);
endmodule

bind dma_start_gate dma_start_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .req_mode    (req_mode),
    .periph_req  (periph_req),
    .term_count  (term_count),
    .xfer_ok     (xfer_ok),
    .xfer_active (xfer_active),
    .flags       (flags)
);

// File: tb/dma_start_gate_bench.sv
`timescale 1ns/1ps
module dma_start_gate_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_rd, reg_wr;
    logic [3:0] reg_wdata;
    logic [3:0] reg_rdata;
    logic       master_en, te_mask, req_pol;
    logic [1:0] req_mode;
    logic       ext_req_async, periph_req;
    logic       term_count, nmi_event, addr_err_event;
    logic       xfer_ok, xfer_active;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    dma_start_gate u_dma_start_gate (
        .clk            (clk),
        .rst            (rst),
        .reg_rd         (reg_rd),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .master_en      (master_en),
        .te_mask        (te_mask),
        .req_mode       (req_mode),
        .req_pol        (req_pol),
        .ext_req_async  (ext_req_async),
        .periph_req     (periph_req),
        .term_count     (term_count),
        .nmi_event      (nmi_event),
        .addr_err_event (addr_err_event),
        .xfer_ok        (xfer_ok),
        .xfer_active    (xfer_active)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_reg(input logic [3:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = 4'h0;
        #1;
    endtask

    task automatic rd_reg();
        reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
        master_en = 0; te_mask = 0; req_pol = 1; req_mode = 2'd0;
        ext_req_async = 0; periph_req = 0;
        term_count = 0; nmi_event = 0; addr_err_event = 0;
        ticks(2);
        rst = 1'b0;
        #1;
    endtask

    function automatic logic blocked(input int m, input logic mk, input logic [2:0] f);
        if (m == 1 || m == 3) return f[1] | f[2] | (f[0] & ~mk);
        return |f;
    endfunction

    task automatic pulse_flags(input logic [2:0] f);
        term_count = f[0]; nmi_event = f[1]; addr_err_event = f[2];
        tick();
        term_count = 0; nmi_event = 0; addr_err_event = 0;
    endtask

    task automatic sweep_case(input int m, input logic mk, input logic [2:0] f);
        logic b;
        string tag;
        b = blocked(m, mk, f);
        tag = (m == 0) ? "R2" : (m == 2) ? "R5" : "R4";
        do_reset();
        req_mode = m[1:0]; te_mask = mk; req_pol = 1'b1; master_en = 1'b1;
        pulse_flags(f);
        wr_reg(4'b0001);
        check("R7 blind zero write keeps flags", {4'h0, reg_rdata}, {4'h0, f, 1'b1});
        if (m == 0)
            check("R2 auto start on enable", {7'h0, xfer_ok}, {7'h0, ~b});
        else
            check("R3 no start without request", {7'h0, xfer_ok}, 8'h0);
        if (m == 3) periph_req = 1'b1;
        else if (m != 0) ext_req_async = 1'b1;
        ticks(4);
        #1;
        check(tag, {7'h0, xfer_ok}, {7'h0, ~b});
        check("R12 active after permit", {7'h0, xfer_active}, {7'h0, ~b});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 rdata", {4'h0, reg_rdata}, 8'h00);
        check("R1 xfer_ok", {7'h0, xfer_ok}, 8'h00);
        check("R1 active", {7'h0, xfer_active}, 8'h00);

        // sweep every mode x mask x flag pattern
        for (int m = 0; m < 4; m++)
            for (int mk = 0; mk < 2; mk++)
                for (int f = 0; f < 8; f++)
                    sweep_case(m, mk[0], f[2:0]);

        // R2 / R6: master enable, enable readback, disable stops
        do_reset();
        req_mode = 2'd0;
        wr_reg(4'b0001);
        check("R2 master_en low blocks", {7'h0, xfer_ok}, 8'h00);
        master_en = 1'b1; #1;
        check("R2 master_en high permits", {7'h0, xfer_ok}, 8'h01);
        check("R6 enable readback", {7'h0, reg_rdata[0]}, 8'h01);
        tick(); #1;
        wr_reg(4'b0000);
        check("R6 disable drops xfer_ok", {7'h0, xfer_ok}, 8'h00);
        check("R6 enable reads 0", {7'h0, reg_rdata[0]}, 8'h00);
        tick(); #1;
        check("R6 active drops", {7'h0, xfer_active}, 8'h00);

        // R11 terminal count, then restart in level mode with mask
        do_reset();
        req_mode = 2'd0; master_en = 1'b1;
        wr_reg(4'b0001);
        tick(); #1;
        term_count = 1'b1; #1;
        check("R11 tc blocks same cycle", {7'h0, xfer_ok}, 8'h00);
        tick();
        term_count = 1'b0; #1;
        check("R11 active dropped", {7'h0, xfer_active}, 8'h00);
        check("R11 te flag set", {7'h0, reg_rdata[1]}, 8'h01);
        check("R11 auto stays blocked", {7'h0, xfer_ok}, 8'h00);
        req_mode = 2'd1; te_mask = 1'b1; ext_req_async = 1'b1;
        ticks(3); #1;
        check("R11 level restart with mask", {7'h0, xfer_ok}, 8'h01);
        te_mask = 1'b0; #1;
        check("R11 level blocked without mask", {7'h0, xfer_ok}, 8'h00);

        // R10 level latency
        do_reset();
        req_mode = 2'd1; master_en = 1'b1;
        wr_reg(4'b0001);
        ext_req_async = 1'b1;
        tick(); #1;
        check("R10 level after 1 cycle", {7'h0, xfer_ok}, 8'h00);
        tick(); #1;
        check("R10 level after 2 cycles", {7'h0, xfer_ok}, 8'h01);

        // R10 rising edge latency
        do_reset();
        req_mode = 2'd2; master_en = 1'b1;
        wr_reg(4'b0001);
        ext_req_async = 1'b1;
        ticks(2); #1;
        check("R10 edge after 2 cycles", {7'h0, xfer_ok}, 8'h00);
        tick(); #1;
        check("R10 edge after 3 cycles", {7'h0, xfer_ok}, 8'h01);

        // R10 pending held across a blocking flag
        do_reset();
        req_mode = 2'd2; master_en = 1'b1;
        pulse_flags(3'b010);
        wr_reg(4'b0001);
        ext_req_async = 1'b1;
        ticks(4); #1;
        check("R10 edge blocked by nmi", {7'h0, xfer_ok}, 8'h00);
        rd_reg();
        wr_reg(4'b0001);
        check("R10 pending served after clear", {7'h0, xfer_ok}, 8'h01);

        // R10 pending lost on disable
        do_reset();
        req_mode = 2'd2; master_en = 1'b1;
        pulse_flags(3'b010);
        wr_reg(4'b0001);
        ext_req_async = 1'b1;
        ticks(4);
        wr_reg(4'b0000);
        rd_reg();
        wr_reg(4'b0001);
        check("R10 pending lost on disable", {7'h0, xfer_ok}, 8'h00);

        // R10 falling edge polarity
        do_reset();
        req_mode = 2'd2; master_en = 1'b1; req_pol = 1'b0; ext_req_async = 1'b1;
        ticks(4);
        wr_reg(4'b0001);
        check("R10 no start on rising with pol 0", {7'h0, xfer_ok}, 8'h00);
        ext_req_async = 1'b0;
        ticks(3); #1;
        check("R10 falling edge start", {7'h0, xfer_ok}, 8'h01);

        // R7 clear handshake
        do_reset();
        pulse_flags(3'b010);
        wr_reg(4'b0000);
        check("R7 zero write without read", {7'h0, reg_rdata[2]}, 8'h01);
        rd_reg();
        wr_reg(4'b0100);
        check("R7 write one keeps flag", {7'h0, reg_rdata[2]}, 8'h01);
        wr_reg(4'b0000);
        check("R7 write disarms", {7'h0, reg_rdata[2]}, 8'h01);
        rd_reg();
        wr_reg(4'b0000);
        check("R7 read then zero clears", {7'h0, reg_rdata[2]}, 8'h00);
        wr_reg(4'b1110);
        check("R7 write ones never sets", {4'h0, reg_rdata}, 8'h00);

        // R8 read racing the set event
        do_reset();
        nmi_event = 1'b1; reg_rd = 1'b1; #1;
        check("R8 racing read returns 0", {7'h0, reg_rdata[2]}, 8'h00);
        tick();
        nmi_event = 1'b0; reg_rd = 1'b0; #1;
        check("R8 flag now set", {7'h0, reg_rdata[2]}, 8'h01);
        wr_reg(4'b0000);
        check("R8 zero write clears after race", {7'h0, reg_rdata[2]}, 8'h00);

        // R9 set beats clear
        do_reset();
        pulse_flags(3'b100);
        rd_reg();
        reg_wr = 1'b1; reg_wdata = 4'b0000; addr_err_event = 1'b1;
        tick();
        reg_wr = 1'b0; addr_err_event = 1'b0; #1;
        check("R9 set wins over clear", {7'h0, reg_rdata[3]}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule